// File: doc/BRIEF.md
# Paired Mirrored-Write Lookup RAMs

This block holds the two lookup RAMs of an even/odd pair of neighbouring cores. Each core reads and writes its own RAM through a single address, data and write-enable port, and gets read data back one clock later. Each RAM also has a second write port. When a core raises its mirror enable, that second port copies every write its partner core makes, with the same address and data and in the same clock cycle. With both enables raised, every write lands in both RAMs, so the pair behaves as one shared table. That shared table is a low-latency path for passing messages in either direction.

In each cycle, a write steering unit sorts the activity of each RAM into one of five named states. WC_IDLE means no write. WC_LOCAL means only the core's own write. WC_MIRROR means only a replayed partner write. WC_DUAL means both writes go ahead, to different addresses. WC_CLASH means both writes target the same address, and the local write is kept while the mirrored one is dropped. The state follows directly from the current inputs, so a RAM can move from any state to any other on the next cycle. Core 0 is the even member of the pair and core 1 the odd member. Each core's mirror enable is independent and may change on any cycle.

Top module: `lut_pair_mirror`

## Requirements
- R1: A core's read data shows the word stored in its own RAM at the presented address, on the clock edge after the address was presented.
- R2: A local write (write enable high) stores the data at the address in the core's own RAM, and a later read at that address returns it.
- R3: While a core's mirror enable is high, each write by its partner is stored at the same address in that core's RAM.
- R4: While a core's mirror enable is low, partner writes leave that core's RAM unchanged.
- R5: When a core's local write and a mirrored partner write hit the same address in the same cycle, the RAM keeps the local data.
- R6: A local write and a mirrored write to different addresses in the same cycle both complete.
- R7: The two mirror enables act independently and take effect on the cycle they are set or cleared. With both high, traffic flows both ways and the two RAMs end up holding identical copies of the written words.
- R8: Partner writes on consecutive cycles (a block write) are each mirrored, in the same cycle as the partner's own write.
- R9: While reset is asserted, both read data outputs are zero.
- R10: A read at an address being written in the same cycle returns the word held there before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the read registers |
| c0_addr | input | 9 | Core 0 word address, used for both read and write |
| c0_wdata | input | 32 | Core 0 write data |
| c0_we | input | 1 | Core 0 write enable |
| c0_mirror_en | input | 1 | Core 0 copies core 1's writes when high |
| c0_rdata | output | 32 | Core 0 read data, one cycle after the address |
| c1_addr | input | 9 | Core 1 word address, used for both read and write |
| c1_wdata | input | 32 | Core 1 write data |
| c1_we | input | 1 | Core 1 write enable |
| c1_mirror_en | input | 1 | Core 1 copies core 0's writes when high |
| c1_rdata | output | 32 | Core 1 read data, one cycle after the address |

## Verification
The bench targets these failure cases:
- **Same-address collision.** Both cores write one address with both enables high. A design with the wrong priority leaves the partner's word in each RAM instead of the local one.
- **Gating of mirrored writes.** A word is written and then overwritten by the partner while mirroring is off. A design that ignored the enable would return the partner's data.
- **Run-time enable changes.** The enable is cleared after a mirrored write, and a later partner write must not change the copy.
- **Block transfer.** Sixteen back-to-back writes are checked in the mirroring RAM, which exposes a copy that is delayed, dropped or shifted by one cycle.
- **Read during write.** A read at the address being written must return the old word, so a design that forwards the new data fails.

// File: rtl/lutpair_pkg.sv
package lutpair_pkg;

    // Per-cycle write activity seen by one lookup RAM
    typedef enum logic [2:0] {
        WC_IDLE,    // no write this cycle
        WC_LOCAL,   // own core writes only
        WC_MIRROR,  // partner write replayed only
        WC_DUAL,    // both, different addresses
        WC_CLASH    // both, same address: local kept
    } wr_class_t;

endpackage

// File: rtl/lut_write_steer.sv
module lut_write_steer
    import lutpair_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          loc_we,
    input  logic [AW-1:0] loc_addr,
    input  logic          part_we,
    input  logic [AW-1:0] part_addr,
    input  logic          mirror_en,
    output logic          loc_go,
    output logic          mir_go
);

    wr_class_t cls;
    logic      mir_req;
    logic      same_addr;

    assign mir_req   = mirror_en & part_we;
    assign same_addr = (loc_addr == part_addr);

    // Classification of this cycle's write activity
    always_comb begin
        unique case ({loc_we, mir_req})
            2'b00:   cls = WC_IDLE;
            2'b10:   cls = WC_LOCAL;
            2'b01:   cls = WC_MIRROR;
            2'b11:   cls = same_addr ? WC_CLASH : WC_DUAL;
            default: cls = WC_IDLE;
        endcase
    end

    // Port enables per class
    always_comb begin
        loc_go = 1'b0;
        mir_go = 1'b0;
        unique case (cls)
            WC_IDLE:   begin loc_go = 1'b0; mir_go = 1'b0; end
            WC_LOCAL:  begin loc_go = 1'b1; mir_go = 1'b0; end
            WC_MIRROR: begin loc_go = 1'b0; mir_go = 1'b1; end
            WC_DUAL:   begin loc_go = 1'b1; mir_go = 1'b1; end
            WC_CLASH:  begin loc_go = 1'b1; mir_go = 1'b0; end
            default:   begin loc_go = 1'b0; mir_go = 1'b0; end
        endcase
    end

endmodule

// File: rtl/lut_bank.sv
module lut_bank #(
    parameter int DW    = 32,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          a_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    input  logic          b_we,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    // Mirror port first, local port last so it wins on equal address
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wdata;
        if (a_we) mem[a_addr] <= a_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[a_addr];
    end

    AST_LOCAL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        a_we |=> mem[$past(a_addr)] == $past(a_wdata)); // R2

    AST_MIRROR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (b_we && !(a_we && a_addr == b_addr)) |=> mem[$past(b_addr)] == $past(b_wdata)); // R6

    AST_RD_QUIET_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0); // R9

endmodule

// File: rtl/lut_pair_mirror.sv
module lut_pair_mirror #(
    parameter int DW    = 32,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int NCORE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] c0_addr,
    input  logic [DW-1:0] c0_wdata,
    input  logic          c0_we,
    input  logic          c0_mirror_en,
    output logic [DW-1:0] c0_rdata,
    input  logic [AW-1:0] c1_addr,
    input  logic [DW-1:0] c1_wdata,
    input  logic          c1_we,
    input  logic          c1_mirror_en,
    output logic [DW-1:0] c1_rdata
);

    logic [AW-1:0] addr_v  [NCORE];
    logic [DW-1:0] wdata_v [NCORE];
    logic [DW-1:0] rdata_v [NCORE];
    logic          we_v    [NCORE];
    logic          men_v   [NCORE];
    logic          loc_go  [NCORE];
    logic          mir_go  [NCORE];

    assign addr_v[0]  = c0_addr;
    assign addr_v[1]  = c1_addr;
    assign wdata_v[0] = c0_wdata;
    assign wdata_v[1] = c1_wdata;
    assign we_v[0]    = c0_we;
    assign we_v[1]    = c1_we;
    assign men_v[0]   = c0_mirror_en;
    assign men_v[1]   = c1_mirror_en;
    assign c0_rdata   = rdata_v[0];
    assign c1_rdata   = rdata_v[1];

    for (genvar g = 0; g < NCORE; g++) begin : g_lane
        localparam int P = g ^ 1;   // even/odd partner

        lut_write_steer #(.AW(AW)) u_steer (
            .loc_we    (we_v[g]),
            .loc_addr  (addr_v[g]),
            .part_we   (we_v[P]),
            .part_addr (addr_v[P]),
            .mirror_en (men_v[g]),
            .loc_go    (loc_go[g]),
            .mir_go    (mir_go[g])
        );

        lut_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_addr  (addr_v[g]),
            .a_wdata (wdata_v[g]),
            .a_we    (loc_go[g]),
            .b_addr  (addr_v[P]),
            .b_wdata (wdata_v[P]),
            .b_we    (mir_go[g]),
            .rd_data (rdata_v[g])
        );

        AST_MIRROR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            !men_v[g] |-> !mir_go[g]); // R4

        AST_SAME_CYCLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            (men_v[g] && we_v[P] && !(we_v[g] && addr_v[g] == addr_v[P])) |-> mir_go[g]); // R8

        AST_CLASH_LOCAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (we_v[g] && men_v[g] && we_v[P] && addr_v[g] == addr_v[P])
                |-> (loc_go[g] && !mir_go[g])); // R5

        AST_LOCAL_NEVER_LOST: assert property (@(posedge clk) disable iff (!rst_n)
            we_v[g] |-> loc_go[g]); // R2
    end

endmodule

// File: tb/tb_lut_pair_mirror.sv
module tb_lut_pair_mirror;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  c0_addr = '0, c1_addr = '0;
    logic [31:0] c0_wdata = '0, c1_wdata = '0;
    logic        c0_we = 1'b0, c1_we = 1'b0;
    logic        c0_mirror_en = 1'b0, c1_mirror_en = 1'b0;
    logic [31:0] c0_rdata, c1_rdata;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    typedef struct {
        logic [31:0] e0;
        logic [31:0] e1;
        bit          k0;
        bit          k1;
        string       tag;
    } item_t;

    item_t sb_q[$];

    logic [31:0] m0 [DEPTH];
    logic [31:0] m1 [DEPTH];
    bit          v0 [DEPTH];
    bit          v1 [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    lut_pair_mirror dut (
        .clk(clk), .rst_n(rst_n),
        .c0_addr(c0_addr), .c0_wdata(c0_wdata), .c0_we(c0_we),
        .c0_mirror_en(c0_mirror_en), .c0_rdata(c0_rdata),
        .c1_addr(c1_addr), .c1_wdata(c1_wdata), .c1_we(c1_we),
        .c1_mirror_en(c1_mirror_en), .c1_rdata(c1_rdata)
    );

    task automatic report;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Driver: one cycle of stimulus, pushes expected read data
    task automatic step(input int a0, input logic [31:0] d0, input bit w0, input bit e0,
                        input int a1, input logic [31:0] d1, input bit w1, input bit e1,
                        input string tag);
        item_t it;
        @(negedge clk);
        c0_addr = 9'(a0); c0_wdata = d0; c0_we = w0; c0_mirror_en = e0;
        c1_addr = 9'(a1); c1_wdata = d1; c1_we = w1; c1_mirror_en = e1;
        it.e0 = m0[a0]; it.k0 = v0[a0];
        it.e1 = m1[a1]; it.k1 = v1[a1];
        it.tag = tag;
        sb_q.push_back(it);
        // mirror first, local last: local wins on equal address
        if (e0 && w1) begin m0[a1] = d1; v0[a1] = 1'b1; end
        if (w0)       begin m0[a0] = d0; v0[a0] = 1'b1; end
        if (e1 && w0) begin m1[a0] = d0; v1[a0] = 1'b1; end
        if (w1)       begin m1[a1] = d1; v1[a1] = 1'b1; end
    endtask

    task automatic rd(input int a0, input int a1, input bit e0, input bit e1, input string tag);
        step(a0, 32'h0, 1'b0, e0, a1, 32'h0, 1'b0, e1, tag);
    endtask

    // Monitor: compares one result per cycle, a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (rst_n && sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                if (it.k0) begin
                    total++;
                    if (c0_rdata !== it.e0) begin
                        bad++;
                        $display("FAIL %s core0 rdata got %h expected %h", it.tag, c0_rdata, it.e0);
                    end
                end
                if (it.k1) begin
                    total++;
                    if (c1_rdata !== it.e1) begin
                        bad++;
                        $display("FAIL %s core1 rdata got %h expected %h", it.tag, c1_rdata, it.e1);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog run hung got timeout expected completion");
            report();
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m0[i] = '0; m1[i] = '0; v0[i] = 1'b0; v1[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R9: outputs zero while in reset
        total++;
        if (c0_rdata !== 32'h0 || c1_rdata !== 32'h0) begin
            bad++;
            $display("FAIL R9 reset rdata got %h/%h expected 0/0", c0_rdata, c1_rdata);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: private writes, mirroring off
        step(3, 32'hA0A0_0003, 1, 0, 10, 32'h0000_1111, 1, 0, "R2");
        // R4: core0 overwrites 10 while core1 mirror is off
        step(10, 32'h0000_2222, 1, 0, 0, 32'h0, 0, 0, "R4");
        rd(10, 10, 0, 0, "R4");
        rd(3, 10, 0, 0, "R1");

        // R3: core1 mirrors core0
        step(20, 32'hCAFE_0020, 1, 0, 0, 32'h0, 0, 1, "R3");
        rd(20, 20, 0, 1, "R3");

        // R5: same-address clash, both mirroring
        step(50, 32'h0000_050A, 1, 1, 50, 32'h0000_050B, 1, 1, "R5");
        rd(50, 50, 1, 1, "R5");

        // R6/R7: different addresses, both directions
        step(60, 32'h0000_0600, 1, 1, 61, 32'h0000_0611, 1, 1, "R6");
        rd(61, 60, 1, 1, "R6");
        rd(60, 61, 1, 1, "R7");

        // R8: block of back-to-back writes mirrored into core1
        for (int i = 0; i < 16; i++)
            step(100 + i, 32'hB000_0000 + i, 1, 0, 100 + i, 32'h0, 0, 1, "R8");
        for (int i = 0; i < 16; i++)
            rd(100 + i, 100 + i, 0, 1, "R8");

        // R7: clearing the enable at run time stops mirroring
        step(20, 32'hDEAD_0020, 1, 0, 0, 32'h0, 0, 0, "R7");
        rd(20, 20, 0, 0, "R7");

        // R10: read during write returns the old word
        step(3, 32'h0000_0033, 1, 0, 0, 32'h0, 0, 0, "R10");
        rd(3, 0, 0, 0, "R10");

        repeat (4) @(negedge clk);
        ended = 1;
        report();
    end

endmodule